// File: doc/BRIEF.md
# Eight-Input Prioritised Interrupt Controller

The block collects eight interrupt request lines and tells the processor, on a single interrupt output, when a request is waiting that outranks everything currently being serviced. Software programs it through a byte-wide port with one address bit. After reset or a restart, a short series of setup bytes supplies the trigger style, the vector base, an optional cascade word and an optional mode word. After that, the odd address holds the mask. Command bytes at the even address issue end-of-interrupt, switch special mask mode on and off, and choose whether even-address reads return pending requests or the in-service set.

The processor acknowledges with a level input. On the rising edge of that input the block picks the winning request, moves it into service and presents an 8-bit vector. The vector is the upper five bits of the programmed base with the input number in the low three bits. Service ends either with a non-specific end-of-interrupt command or, in automatic mode, when the acknowledge input falls. Cascade wiring is not driven; the cascade setup byte is only kept.

Top module: `irqc_core`

## Requirements
- R1: After reset the mask is 0xFF, pending (IRR) and in-service (ISR) sets are 0, even-address reads select IRR, the block is ready for normal operation in single edge mode with vector base 0, `cpu_int` is low and `ack_vector` is 0x00.
- R2: A write at address 0 with data bit 4 set restarts setup. Bit 0 means a mode byte will follow, bit 1 set means single operation (no cascade byte), and bit 3 set means level triggering. The same write clears the mask, IRR, ISR, special mask mode and automatic end-of-interrupt, and selects IRR for reads.
- R3: After a restart, odd-address writes go in this order: vector base first, then the cascade byte (only when bit 1 was 0), then the mode byte (only when bit 0 was 1). Later odd-address writes load the mask. An odd-address read returns the mask.
- R4: In edge mode an IRR bit is set on the clock after its request input rises, and stays set until that input is acknowledged or setup restarts.
- R5: In level mode each IRR bit equals its request input as sampled on the previous clock, and acknowledge does not clear it.
- R6: Input 0 has the highest priority. `cpu_int` is high exactly when some IRR bit whose mask bit is 0 has a lower index than every set ISR bit. A mask bit of 1 blocks that input but IRR still records it.
- R7: On a rising edge of `int_ack` with `cpu_int` high, the winning input's ISR bit is set and, in edge mode, its IRR bit cleared. From the next cycle `ack_vector` = {base[7:3], input number} and holds until the next rising edge. With no winner, the number is 7 and ISR and IRR are unchanged.
- R8: With mode-byte bit 1 set (automatic end-of-interrupt), the ISR bit set by an acknowledge is cleared on the clock after `int_ack` falls.
- R9: An even-address write of 0x20 with data bits 4 and 3 clear clears the lowest-index set ISR bit. Other values with bits 4 and 3 clear change nothing.
- R10: An even-address write with bit 4 clear and bit 3 set: bits 1:0 = 10 select IRR and 11 select ISR for even-address reads; bits 6:5 = 10 clear and 11 set special mask mode; other values of those fields leave the setting unchanged.
- R11: In special mask mode, ISR bits of masked inputs do not block lower-priority requests.
- R12: `reg_rdata` is 0x00 whenever `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register address bit |
| reg_wr | input | 1 | Write strobe, one byte per cycle it is high |
| reg_rd | input | 1 | Read strobe, qualifies `reg_rdata` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (mask, IRR or ISR) |
| irq_req | input | 8 | Interrupt request inputs, bit 0 highest priority |
| int_ack | input | 1 | Acknowledge level from the processor |
| ack_vector | output | 8 | Vector of the last acknowledge |
| cpu_int | output | 1 | Interrupt request to the processor |

## Verification
The checker watches, on every cycle, the rules that relate state across one clock. These are: the interrupt output only asserts with an unmasked pending bit; edge capture of request rises; level tracking; exactly one in-service bit added per granted acknowledge; one bit removed per end-of-interrupt; in-service emptied after an automatic-mode acknowledge; and the idle read bus. Only the bench scenarios can show the setup-byte ordering, nested priority across several requests, the exact vector values, the spurious vector, special-mask unblocking and the ignored command codes. Those need specific programming sequences and expected values.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IRQ_N  = 8;
  localparam int ID_W   = $clog2(IRQ_N);
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] EOI_NONSPEC = 8'h20;

  typedef enum logic [1:0] {
    CFG_RUN  = 2'd0,
    CFG_BASE = 2'd1,
    CFG_CASC = 2'd2,
    CFG_MODE = 2'd3
  } cfg_state_e;

  typedef struct packed {
    logic            hit;
    logic [ID_W-1:0] id;
  } pick_t;

  // lowest set index wins
  function automatic pick_t pick_lowest(input logic [IRQ_N-1:0] v);
    pick_t r;
    r = '0;
    for (int i = IRQ_N - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.hit = 1'b1;
        r.id  = ID_W'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_odd,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [IRQ_N-1:0]  mask_o,
  output logic [BYTE_W-1:0] base_o,
  output logic              level_o,
  output logic              aeoi_o,
  output logic              smm_o,
  output logic              sel_isr_o,
  output logic              init_o,
  output logic              eoi_o
);
  cfg_state_e        st_q, st_d;
  logic              need_mode_q, need_mode_d;
  logic              single_q, single_d;
  logic              level_q, level_d;
  logic              smm_q, smm_d;
  logic              sel_q, sel_d;
  logic [IRQ_N-1:0]  mask_q, mask_d;
  logic [BYTE_W-1:0] base_q, base_d;
  logic [BYTE_W-1:0] casc_q, casc_d;
  logic [BYTE_W-1:0] mode_q, mode_d;

  logic cmd_wr, odd_wr, is_init, is_sel, is_ctl;

  assign cmd_wr  = wr_en & ~wr_odd;
  assign odd_wr  = wr_en & wr_odd;
  assign is_init = cmd_wr & wr_data[4];
  assign is_sel  = cmd_wr & ~wr_data[4] & wr_data[3];
  assign is_ctl  = cmd_wr & ~wr_data[4] & ~wr_data[3];

  always_comb begin
    st_d        = st_q;
    need_mode_d = need_mode_q;
    single_d    = single_q;
    level_d     = level_q;
    smm_d       = smm_q;
    sel_d       = sel_q;
    mask_d      = mask_q;
    base_d      = base_q;
    casc_d      = casc_q;
    mode_d      = mode_q;
    if (is_init) begin
      st_d        = CFG_BASE;
      need_mode_d = wr_data[0];
      single_d    = wr_data[1];
      level_d     = wr_data[3];
      smm_d       = 1'b0;
      sel_d       = 1'b0;
      mask_d      = '0;
      mode_d      = '0;
    end else if (is_sel) begin
      if (wr_data[6]) smm_d = wr_data[5];
      if (wr_data[1]) sel_d = wr_data[0];
    end else if (odd_wr) begin
      unique case (st_q)
        CFG_BASE: begin
          base_d = wr_data;
          if (!single_q)       st_d = CFG_CASC;
          else if (need_mode_q) st_d = CFG_MODE;
          else                 st_d = CFG_RUN;
        end
        CFG_CASC: begin
          casc_d = wr_data;
          st_d   = need_mode_q ? CFG_MODE : CFG_RUN;
        end
        CFG_MODE: begin
          mode_d = wr_data;
          st_d   = CFG_RUN;
        end
        default: mask_d = wr_data[IRQ_N-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= CFG_RUN;
      need_mode_q <= 1'b0;
      single_q    <= 1'b1;
      level_q     <= 1'b0;
      smm_q       <= 1'b0;
      sel_q       <= 1'b0;
      mask_q      <= '1;
      base_q      <= '0;
      casc_q      <= '0;
      mode_q      <= '0;
    end else if (wr_en) begin
      st_q        <= st_d;
      need_mode_q <= need_mode_d;
      single_q    <= single_d;
      level_q     <= level_d;
      smm_q       <= smm_d;
      sel_q       <= sel_d;
      mask_q      <= mask_d;
      base_q      <= base_d;
      casc_q      <= casc_d;
      mode_q      <= mode_d;
    end
  end

  // cascade byte and the other mode bits are kept but drive no logic
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{casc_q, mode_q[BYTE_W-1:2], mode_q[0]};

  assign mask_o    = mask_q;
  assign base_o    = base_q;
  assign level_o   = level_q;
  assign aeoi_o    = mode_q[1];
  assign smm_o     = smm_q;
  assign sel_isr_o = sel_q;
  assign init_o    = is_init;
  assign eoi_o     = is_ctl & (wr_data == EOI_NONSPEC);
endmodule

// File: rtl/irqc_req.sv
module irqc_req
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] req_i,
  input  logic             level_i,
  input  logic             clr_all_i,
  input  logic [IRQ_N-1:0] ack_clr_i,
  output logic [IRQ_N-1:0] irr_o
);
  logic [IRQ_N-1:0] prev_q;
  logic [IRQ_N-1:0] irr_q, irr_d;

  for (genvar g = 0; g < IRQ_N; g++) begin : g_cell
    assign irr_d[g] = clr_all_i ? 1'b0 :
                      level_i   ? req_i[g] :
                      ((irr_q[g] & ~ack_clr_i[g]) | (req_i[g] & ~prev_q[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= req_i;
      irr_q  <= irr_d;
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
  import irqc_pkg::*;
(
  input  logic [IRQ_N-1:0] irr_i,
  input  logic [IRQ_N-1:0] mask_i,
  input  logic [IRQ_N-1:0] isr_i,
  input  logic             smm_i,
  output logic             win_o,
  output logic [ID_W-1:0]  win_id_o
);
  logic [IRQ_N-1:0] cand, block;
  pick_t r, b;

  assign cand  = irr_i & ~mask_i;
  assign block = smm_i ? (isr_i & ~mask_i) : isr_i;

  always_comb begin
    r        = pick_lowest(cand);
    b        = pick_lowest(block);
    win_o    = r.hit & (~b.hit | (r.id < b.id));
    win_id_o = r.id;
  end
endmodule

// File: rtl/irqc_svc.sv
module irqc_svc
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_i,
  input  logic             win_i,
  input  logic [ID_W-1:0]  win_id_i,
  input  logic             aeoi_i,
  input  logic             init_i,
  input  logic             eoi_i,
  output logic [IRQ_N-1:0] isr_o,
  output logic [ID_W-1:0]  vec_id_o,
  output logic [IRQ_N-1:0] ack_clr_o
);
  logic             ack_q;
  logic             hit_q, hit_d;
  logic [ID_W-1:0]  vid_q, vid_d;
  logic [IRQ_N-1:0] isr_q, isr_d;
  logic [IRQ_N-1:0] set_v, eoi_v, auto_v;
  logic             rise, fall, upd;
  pick_t            top;

  assign rise = ack_i & ~ack_q;
  assign fall = ~ack_i & ack_q;
  assign top  = pick_lowest(isr_q);

  for (genvar g = 0; g < IRQ_N; g++) begin : g_dec
    assign set_v[g]  = rise & win_i & (win_id_i == ID_W'(g));
    assign eoi_v[g]  = eoi_i & top.hit & (top.id == ID_W'(g));
    assign auto_v[g] = fall & aeoi_i & hit_q & (vid_q == ID_W'(g));
  end

  always_comb begin
    isr_d = init_i ? '0 : ((isr_q & ~eoi_v & ~auto_v) | set_v);
    hit_d = hit_q;
    vid_d = vid_q;
    if (init_i) begin
      hit_d = 1'b0;
    end else if (rise) begin
      hit_d = win_i;
      vid_d = win_i ? win_id_i : '1;
    end
  end

  assign upd = rise | fall | eoi_i | init_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      hit_q <= 1'b0;
      vid_q <= '0;
      isr_q <= '0;
    end else begin
      ack_q <= ack_i;
      if (upd) begin
        hit_q <= hit_d;
        vid_q <= vid_d;
        isr_q <= isr_d;
      end
    end
  end

  assign isr_o     = isr_q;
  assign vec_id_o  = vid_q;
  assign ack_clr_o = set_v;
endmodule

// File: rtl/irqc_core.sv
module irqc_core
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [IRQ_N-1:0]  irq_req,
  input  logic              int_ack,
  output logic [BYTE_W-1:0] ack_vector,
  output logic              cpu_int
);
  logic [IRQ_N-1:0]  mask_w, irr_w, isr_w, ack_clr_w;
  logic [BYTE_W-1:0] base_w;
  logic              level_w, aeoi_w, smm_w, sel_isr_w, init_w, eoi_w;
  logic              win_w;
  logic [ID_W-1:0]   win_id_w, vec_id_w;

  irqc_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_odd(reg_addr),
    .wr_data(reg_wdata), .mask_o(mask_w), .base_o(base_w),
    .level_o(level_w), .aeoi_o(aeoi_w), .smm_o(smm_w),
    .sel_isr_o(sel_isr_w), .init_o(init_w), .eoi_o(eoi_w)
  );

  irqc_req u_req (
    .clk(clk), .rst_n(rst_n), .req_i(irq_req), .level_i(level_w),
    .clr_all_i(init_w), .ack_clr_i(ack_clr_w), .irr_o(irr_w)
  );

  irqc_prio u_prio (
    .irr_i(irr_w), .mask_i(mask_w), .isr_i(isr_w), .smm_i(smm_w),
    .win_o(win_w), .win_id_o(win_id_w)
  );

  irqc_svc u_svc (
    .clk(clk), .rst_n(rst_n), .ack_i(int_ack), .win_i(win_w),
    .win_id_i(win_id_w), .aeoi_i(aeoi_w), .init_i(init_w), .eoi_i(eoi_w),
    .isr_o(isr_w), .vec_id_o(vec_id_w), .ack_clr_o(ack_clr_w)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr)       reg_rdata = mask_w;
      else if (sel_isr_w) reg_rdata = isr_w;
      else                reg_rdata = irr_w;
    end
  end

  logic unused_base_lo;
  assign unused_base_lo = ^base_w[BYTE_W-ID_W-1:0];

  assign ack_vector = {base_w[BYTE_W-1:ID_W], vec_id_w};
  assign cpu_int    = win_w;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic [IRQ_N-1:0]  irq_req,
  input logic              int_ack,
  input logic              cpu_int,
  input logic [IRQ_N-1:0]  irr,
  input logic [IRQ_N-1:0]  isr,
  input logic [IRQ_N-1:0]  mask,
  input logic              level,
  input logic              aeoi
);
  logic init_wr;
  assign init_wr = reg_wr & ~reg_addr & reg_wdata[4];

  // R6
  a_r6_int_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> ((irr & ~mask) != '0));

  // R4
  a_r4_edge_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (!level && !init_wr) |=> ((irr & $past(irq_req & ~$past(irq_req))) ==
                              $past(irq_req & ~$past(irq_req))));

  // R5
  a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (level && !init_wr) |=> (irr == $past(irq_req)));

  // R7
  a_r7_grant_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_ack) && cpu_int && !init_wr) |=>
      ($countones(isr & ~$past(isr)) == 1));

  // R8
  a_r8_auto_end_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi && $fell(int_ack) && !reg_wr) |=> (isr == '0));

  // R9
  a_r9_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr && reg_wdata == EOI_NONSPEC && isr != '0 &&
     !int_ack && !$past(int_ack)) |=>
      ($countones(isr) == $countones($past(isr)) - 1));

  // R12
  a_r12_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == '0));
endmodule

bind irqc_core irqc_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_req(irq_req), .int_ack(int_ack), .cpu_int(cpu_int),
  .irr(irr_w), .isr(isr_w), .mask(mask_w), .level(level_w), .aeoi(aeoi_w)
);

// File: tb/test_irqc_core.sv
module test_irqc_core;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NT = 20;
  // {read, addr, data, expected}
  localparam logic [17:0] TBL [NT] = '{
    {1'b0, 1'b0, 8'h11, 8'h00}, {1'b1, 1'b1, 8'h00, 8'h00},
    {1'b0, 1'b1, 8'h40, 8'h00}, {1'b0, 1'b1, 8'h04, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'h00}, {1'b0, 1'b1, 8'h01, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'h00}, {1'b0, 1'b1, 8'hA5, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'hA5}, {1'b0, 1'b0, 8'h0B, 8'h00},
    {1'b1, 1'b0, 8'h00, 8'h00}, {1'b0, 1'b0, 8'h12, 8'h00},
    {1'b0, 1'b1, 8'h48, 8'h00}, {1'b0, 1'b1, 8'h3C, 8'h00},
    {1'b1, 1'b1, 8'h00, 8'h3C}, {1'b0, 1'b0, 8'h1B, 8'h00},
    {1'b0, 1'b1, 8'h20, 8'h00}, {1'b0, 1'b1, 8'h5A, 8'h00},
    {1'b0, 1'b1, 8'h81, 8'h00}, {1'b1, 1'b1, 8'h00, 8'h81}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_addr, reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] irq_req;
  logic       int_ack;
  logic [7:0] ack_vector;
  logic       cpu_int;
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irqc_core i_irqc_core (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .int_ack(int_ack), .ack_vector(ack_vector),
    .cpu_int(cpu_int)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic a, input logic [7:0] exp);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
    reg_rd = 1'b0;
  endtask

  task automatic setreq(input logic [7:0] v);
    irq_req = v;
    @(negedge clk);
  endtask

  task automatic ack_begin();
    int_ack = 1'b1;
    @(negedge clk);
  endtask

  task automatic ack_end();
    int_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_addr = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_wdata = 8'h00; irq_req = 8'h00; int_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1 mask", 1'b1, 8'hFF);
    rd("R1 irr", 1'b0, 8'h00);
    chk("R1 cpu_int", {7'd0, cpu_int}, 8'h00);
    chk("R1 vector", ack_vector, 8'h00);

    // R3 setup ordering and mask access, table driven
    for (int i = 0; i < NT; i++) begin
      if (TBL[i][17]) rd("R3 table read", TBL[i][16], TBL[i][7:0]);
      else            wr(TBL[i][16], TBL[i][15:8]);
    end

    // R12 idle read bus while mask is nonzero
    #1 chk("R12 idle rdata", reg_rdata, 8'h00);

    // edge mode, base 0x20
    wr(1'b0, 8'h12); wr(1'b1, 8'h20);
    setreq(8'h20);
    chk("R6 int on request", {7'd0, cpu_int}, 8'h01);
    rd("R4 edge capture", 1'b0, 8'h20);
    setreq(8'h24);
    ack_begin();
    chk("R7 vector input 2", ack_vector, 8'h22);
    ack_end();
    chk("R6 lower blocked by isr", {7'd0, cpu_int}, 8'h00);
    wr(1'b0, 8'h0B);
    rd("R10 isr select", 1'b0, 8'h04);
    wr(1'b0, 8'h0A);
    rd("R7 irr bit cleared", 1'b0, 8'h20);
    wr(1'b0, 8'h20);
    chk("R9 eoi frees lower", {7'd0, cpu_int}, 8'h01);
    ack_begin();
    chk("R7 vector input 5", ack_vector, 8'h25);
    ack_end();
    setreq(8'h26);
    chk("R6 nested higher", {7'd0, cpu_int}, 8'h01);
    ack_begin();
    chk("R7 vector input 1", ack_vector, 8'h21);
    ack_end();
    wr(1'b0, 8'h0B);
    rd("R7 two in service", 1'b0, 8'h22);
    wr(1'b0, 8'h60);
    rd("R9 other code ignored", 1'b0, 8'h22);
    wr(1'b0, 8'h20);
    rd("R9 lowest index cleared", 1'b0, 8'h20);
    wr(1'b0, 8'h20);
    rd("R9 second eoi", 1'b0, 8'h00);

    // mask
    wr(1'b1, 8'h08);
    setreq(8'h2E);
    chk("R6 masked no int", {7'd0, cpu_int}, 8'h00);
    wr(1'b0, 8'h0A);
    rd("R6 masked still pending", 1'b0, 8'h08);
    wr(1'b1, 8'h00);
    chk("R6 unmask raises", {7'd0, cpu_int}, 8'h01);
    ack_begin();
    chk("R7 vector input 3", ack_vector, 8'h23);
    ack_end();

    // special mask mode
    wr(1'b1, 8'h08);
    setreq(8'h6E);
    chk("R11 blocked without smm", {7'd0, cpu_int}, 8'h00);
    wr(1'b0, 8'h68);
    chk("R11 smm unblocks", {7'd0, cpu_int}, 8'h01);
    wr(1'b0, 8'h48);
    chk("R10 smm cleared", {7'd0, cpu_int}, 8'h00);

    // spurious acknowledge
    ack_begin();
    chk("R7 spurious vector", ack_vector, 8'h27);
    ack_end();
    wr(1'b0, 8'h0B);
    rd("R7 spurious isr kept", 1'b0, 8'h08);
    wr(1'b0, 8'h0A);
    rd("R7 spurious irr kept", 1'b0, 8'h40);

    // restart clears state
    wr(1'b0, 8'h12);
    chk("R2 int cleared", {7'd0, cpu_int}, 8'h00);
    rd("R2 irr cleared", 1'b0, 8'h00);
    wr(1'b1, 8'h30);
    rd("R2 mask cleared", 1'b1, 8'h00);
    wr(1'b0, 8'h0B);
    rd("R2 isr cleared", 1'b0, 8'h00);

    // automatic end of interrupt
    setreq(8'h00);
    wr(1'b0, 8'h13); wr(1'b1, 8'h20); wr(1'b1, 8'h02);
    wr(1'b0, 8'h0B);
    setreq(8'h10);
    ack_begin();
    chk("R8 vector input 4", ack_vector, 8'h24);
    rd("R8 isr during ack", 1'b0, 8'h10);
    ack_end();
    rd("R8 isr after ack", 1'b0, 8'h00);

    // level mode
    setreq(8'h00);
    wr(1'b0, 8'h1A); wr(1'b1, 8'h20);
    setreq(8'h40);
    rd("R5 level high", 1'b0, 8'h40);
    chk("R5 level int", {7'd0, cpu_int}, 8'h01);
    ack_begin();
    chk("R5 level vector", ack_vector, 8'h26);
    ack_end();
    rd("R5 irr kept after ack", 1'b0, 8'h40);
    setreq(8'h00);
    rd("R5 level low", 1'b0, 8'h00);

    finish_run();
  end
endmodule